// File: doc/BRIEF.md
# Configurable Sum-of-Products Array

This block is a run-time programmable two-level logic array. A set of external inputs, plus one fed-back state bit per output, is presented to an AND plane as both true and inverted literals. Every product term has one connection bit per literal. The products are combined by a fixed OR plane in which each output owns a private, contiguous group of terms.

Each output then passes through a small macrocell. The macrocell chooses the polarity of the output and chooses whether the output shows the OR result directly or the value held in a per-output flip-flop. The flip-flops feed back into the AND plane, so the same array can hold combinational functions or small state machines.

The whole configuration image is loaded through a one-bit serial port. While loading is in progress the outputs are held low and the state flip-flops keep their values.

Top module: `sop_array`

## Requirements
- R1: Every signal (input bit `i` is signal `i`; feedback of output `o` is signal `N_IN+o`) offers two literals to the AND plane: literal `2*s` is the true value and literal `2*s+1` is the inverse. Configuration bit `t*2*(N_IN+N_OUT)+l` set to 1 includes literal `l` in product term `t`, and the term is the AND of its included literals.
- R2: A product term with no literal included evaluates to 0 and never asserts an output.
- R3: Output `o` is the OR of terms `o*TERMS_PER_OUT` through `o*TERMS_PER_OUT+TERMS_PER_OUT-1` only; no term reaches two outputs.
- R4: Configuration bit `AND_W+2*o` selects the polarity of output `o`: with 0 the output follows the selected value, with 1 it is inverted.
- R5: Configuration bit `AND_W+2*o+1` set to 1 selects registered mode: the output shows the flip-flop of output `o`, which takes the OR result on the rising clock edge.
- R6: The feedback literals of output `o` come from its flip-flop before the polarity inversion. The flip-flop captures the OR result on every clock edge in both modes, so in combinational mode the feedback lags the OR result by one clock.
- R7: While `cfg_en` is 1, one bit of `cfg_din` is shifted in per clock, and the configuration is complete after `AND_W+2*N_OUT` clocks. The first bit shifted lands at configuration bit index 0, and later bits land at increasing indices. All outputs are 0 and the flip-flops keep their values while `cfg_en` is 1.
- R8: `rst` is active-high and synchronous, and clears all macrocell flip-flops to 0.
- R9: All `TERMS_PER_OUT` terms of a group contribute to its output. A three-input odd-parity function built from four terms is produced exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high clear of the state flip-flops |
| cfg_en | input | 1 | Configuration shift enable; the array is idle while it is high |
| cfg_din | input | 1 | Serial configuration data bit |
| in_data | input | N_IN | Array inputs |
| out_data | output | N_OUT | Macrocell outputs |

## Verification
The assertions assume that `rst` and `cfg_en` change only between clock edges. They also assume that a full image of `AND_W+2*N_OUT` bits is shifted in before the outputs are taken as meaningful, since the configuration store has no reset value. The bench drives every input one time unit after a falling edge. It compares outputs against its reference model only after the first complete load. It reloads the whole image whenever it changes the function, including while a state machine is counting, so that the hold behaviour is visible across the reload.

// File: rtl/sop_array.sv
module sop_array #(
  parameter int N_IN          = 4,
  parameter int N_OUT         = 2,
  parameter int TERMS_PER_OUT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_din,
  input  logic [N_IN-1:0]  in_data,
  output logic [N_OUT-1:0] out_data
);
  localparam int N_SIG   = N_IN + N_OUT;
  localparam int N_LIT   = 2 * N_SIG;
  localparam int N_TERMS = N_OUT * TERMS_PER_OUT;
  localparam int AND_W   = N_TERMS * N_LIT;
  localparam int CFG_W   = AND_W + 2 * N_OUT;

  logic [CFG_W-1:0]   cfg_q;
  logic [N_OUT-1:0]   fb_q, sum, mc_pol, mc_reg;
  logic [N_SIG-1:0]   sig;
  logic [N_LIT-1:0]   lit;
  logic [N_TERMS-1:0] term;

  always_ff @(posedge clk)
    if (cfg_en) cfg_q <= {cfg_din, cfg_q[CFG_W-1:1]};

  assign sig = {fb_q, in_data};

  for (genvar s = 0; s < N_SIG; s++) begin : g_lit
    assign lit[2*s]   = sig[s];
    assign lit[2*s+1] = ~sig[s];
  end

  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    logic [N_LIT-1:0] conn;
    assign conn    = cfg_q[t*N_LIT +: N_LIT];
    assign term[t] = (|conn) & (&(lit | ~conn));
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assign sum[o]      = |term[o*TERMS_PER_OUT +: TERMS_PER_OUT];
    assign mc_pol[o]   = cfg_q[AND_W + 2*o];
    assign mc_reg[o]   = cfg_q[AND_W + 2*o + 1];
    assign out_data[o] = ~cfg_en & ((mc_reg[o] ? fb_q[o] : sum[o]) ^ mc_pol[o]);
  end

  always_ff @(posedge clk)
    if (rst)          fb_q <= '0;
    else if (!cfg_en) fb_q <= sum;
endmodule

module sop_array_chk #(
  parameter int N_OUT = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_en,
  input logic [N_OUT-1:0] q,
  input logic [N_OUT-1:0] out_data,
  input logic [N_OUT-1:0] mode,
  input logic [N_OUT-1:0] pol
);
  // R7
  idle_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_en |-> out_data == '0);

  // R7
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> $stable(q));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> q == '0);

  for (genvar o = 0; o < N_OUT; o++) begin : g_chk
    // R5
    reg_out_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (!cfg_en && !$past(cfg_en) && mode[o] && $stable(q[o]) && $stable(pol[o]))
        |-> $stable(out_data[o]));

    // R6
    fb_track_chk: assert property (@(posedge clk) disable iff (rst)
      (!cfg_en && !mode[o]) |=> q[o] == $past(out_data[o] ^ pol[o]));
  end
endmodule

bind sop_array sop_array_chk #(.N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .q(fb_q),
  .out_data(out_data), .mode(mc_reg), .pol(mc_pol)
);

// File: tb/test_sop_array.sv
module test_sop_array;
  localparam int N_IN  = 4;
  localparam int N_OUT = 2;
  localparam int TPO   = 8;
  localparam int N_SIG = N_IN + N_OUT;
  localparam int N_LIT = 2 * N_SIG;
  localparam int AND_W = N_OUT * TPO * N_LIT;
  localparam int CFG_W = AND_W + 2 * N_OUT;

  logic clk = 0, rst = 1, cfg_en = 0, cfg_din = 0;
  logic [N_IN-1:0]  in_data = '0;
  logic [N_OUT-1:0] out_data;

  sop_array #(.N_IN(N_IN), .N_OUT(N_OUT), .TERMS_PER_OUT(TPO)) i_sop_array (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .in_data(in_data), .out_data(out_data));

  always #10 clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  string cur_req = "R7";
  bit model_on = 0;
  logic [CFG_W-1:0] img, mcfg;
  logic [N_OUT-1:0] mq = '0;

  task automatic chk(string req, logic [N_OUT-1:0] act, logic [N_OUT-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [N_OUT-1:0] model_sum(logic [CFG_W-1:0] c,
      logic [N_IN-1:0] x, logic [N_OUT-1:0] q);
    logic [N_OUT-1:0] r = '0;
    for (int o = 0; o < N_OUT; o++)
      for (int k = 0; k < TPO; k++) begin
        int t = o * TPO + k;
        bit used = 0, val = 1;
        for (int s = 0; s < N_SIG; s++) begin
          bit v = (s < N_IN) ? x[s] : q[s-N_IN];
          if (c[t*N_LIT+2*s])   begin used = 1; if (!v) val = 0; end
          if (c[t*N_LIT+2*s+1]) begin used = 1; if (v)  val = 0; end
        end
        if (used && val) r[o] = 1;
      end
    return r;
  endfunction

  function automatic logic [N_OUT-1:0] model_out();
    logic [N_OUT-1:0] s = model_sum(mcfg, in_data, mq);
    logic [N_OUT-1:0] r;
    for (int o = 0; o < N_OUT; o++)
      r[o] = (mcfg[AND_W+2*o+1] ? mq[o] : s[o]) ^ mcfg[AND_W+2*o];
    return cfg_en ? '0 : r;
  endfunction

  always @(posedge clk) begin
    if (rst) mq = '0;
    else if (!cfg_en) mq = model_sum(mcfg, in_data, mq);
  end

  always @(negedge clk)
    if (model_on) chk(cur_req, out_data, model_out());

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  function automatic void add_lit(int t, int s, bit inv);
    img[t*N_LIT + 2*s + int'(inv)] = 1'b1;
  endfunction

  function automatic void set_mc(int o, bit pol, bit regm);
    img[AND_W+2*o]   = pol;
    img[AND_W+2*o+1] = regm;
  endfunction

  function automatic void add_min(int t, int val, int nbits);
    for (int s = 0; s < nbits; s++) add_lit(t, s, ((val >> s) & 1) == 0);
  endfunction

  task automatic load();
    for (int k = 0; k < CFG_W; k++) begin
      cfg_en = 1; cfg_din = img[k];
      step();
      if (k == CFG_W/2) chk("R7 idle", out_data, '0);
    end
    cfg_en = 0;
    mcfg = img;
    model_on = 1;
  endtask

  function automatic bit in_set(int v);
    return v == 0 || v == 2 || v == 3 || v == 5 || v == 7 || v == 11 || v == 13 || v == 14;
  endfunction

  int cnt;
  bit [7:0] pat = 8'b1011_1011;

  initial begin
    step(); step();
    // R1 R2 R3: out0 = in0 & ~in1 | in2, out1 = ~in3, other terms empty
    img = '0;
    add_lit(0, 0, 0); add_lit(0, 1, 1);
    add_lit(1, 2, 0);
    add_lit(TPO, 3, 1);
    set_mc(0, 0, 0); set_mc(1, 0, 0);
    cur_req = "R7";
    load();
    rst = 0;
    cur_req = "R3";
    for (int v = 0; v < 16; v++) begin
      in_data = 4'(v); #1;
      chk("R1 R2 R3", out_data,
          {~in_data[3], (in_data[0] & ~in_data[1]) | in_data[2]});
      step();
    end

    // R4: polarity inversion of out0
    set_mc(0, 1, 0);
    load();
    cur_req = "R4";
    for (int v = 0; v < 16; v++) begin
      in_data = 4'(v); #1;
      chk("R4", out_data,
          {~in_data[3], ~((in_data[0] & ~in_data[1]) | in_data[2])});
      step();
    end

    // R9: odd parity from four terms, full group of eight terms on out1
    img = '0;
    add_min(0, 1, 3); add_min(1, 2, 3); add_min(2, 4, 3); add_min(3, 7, 3);
    begin
      int k = 0;
      for (int v = 0; v < 16; v++)
        if (in_set(v)) begin add_min(TPO + k, v, 4); k++; end
    end
    set_mc(0, 0, 0); set_mc(1, 0, 0);
    load();
    cur_req = "R9";
    for (int v = 0; v < 16; v++) begin
      in_data = 4'(v); #1;
      chk("R9", out_data, {in_set(v), ^in_data[2:0]});
      step();
    end

    // R5 R6 R8: two-bit counter with enable on in0, both outputs registered
    img = '0;
    add_lit(0, 4, 0); add_lit(0, 0, 1);
    add_lit(1, 4, 1); add_lit(1, 0, 0);
    add_lit(TPO, 5, 0);   add_lit(TPO, 0, 1);
    add_lit(TPO+1, 5, 0); add_lit(TPO+1, 4, 1);
    add_lit(TPO+2, 5, 1); add_lit(TPO+2, 4, 0); add_lit(TPO+2, 0, 0);
    set_mc(0, 0, 1); set_mc(1, 0, 1);
    in_data = '0;
    load();
    cur_req = "R8";
    rst = 1; step();
    chk("R8 reset", out_data, 2'b00);
    in_data = 4'b0001; step();
    chk("R8 held in reset", out_data, 2'b00);
    rst = 0;
    cur_req = "R5";
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      in_data = {3'b000, pat[i]};
      step();
      cnt = (cnt + int'(pat[i])) % 4;
      chk("R5 R6 count", out_data, 2'(cnt));
    end

    // R7: reload with enable high, state must survive
    in_data = 4'b0001;
    cur_req = "R7";
    load();
    #1 chk("R7 state held", out_data, 2'(cnt));
    step();
    cnt = (cnt + 1) % 4;
    chk("R7 resume", out_data, 2'(cnt));

    // R6: combinational mode, feedback of out0 drives out1 one clock later
    img = '0;
    add_lit(0, 0, 0);
    add_lit(TPO, 4, 0);
    set_mc(0, 0, 0); set_mc(1, 0, 0);
    in_data = '0;
    load();
    step();
    cur_req = "R6";
    in_data = 4'b0001; #1;
    chk("R6 comb", out_data, 2'b01);
    step();
    chk("R6 fb set", out_data, 2'b11);
    in_data = 4'b0000; #1;
    chk("R6 fb lag", out_data, 2'b10);
    step();
    chk("R6 fb clear", out_data, 2'b00);

    step();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule